// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers interrupt requests from eight lines, ranks them by fixed priority (line 0 highest, line 7 lowest) and raises one interrupt output towards a processor. When the processor acknowledges, the controller records the winning line as in service and, on the following cycle, presents an 8-bit vector formed from a programmable base and the line number. Software ends service with a non-specific end-of-interrupt command, which retires the highest-priority line that is in service.

Two register addresses give software its view of the block. The even address takes command bytes: end of interrupt, vector base, register selection for the odd address, and cascade role. The odd address reads and writes either the per-line mask or the per-line trigger-mode register. Each line can be edge-triggered (a high-to-low transition sets a request) or level-triggered (the request follows the line while it is high). When two controllers are chained, the downstream controller's interrupt output feeds line 2 of the upstream one. In that setup the upstream controller runs in master mode and leaves the vector for line 2 to the downstream controller.

Top module: `prio_intc`

## Requirements
- R1: Among requests that are pending and unmasked, the lowest-numbered line is granted. The vector equals the base plus the line number, so base 08h yields 08h..0Fh.
- R2: A mask bit of 1 disables its line and 0 enables it. Reset sets the mask to FFh. A request on a masked edge line is still latched and is presented once the line is unmasked. A write at address 1 while the mask is selected loads the mask.
- R3: `int_out` is high exactly when some enabled request has a line number strictly lower than every in-service line, or when no line is in service.
- R4: With `int_out` high, a one-cycle `inta` pulse sets the granted line's in-service bit and clears its edge request. `vec_valid` is then high for exactly the next cycle, with the vector on `vec_out`. An `inta` pulse while `int_out` is low produces no vector and changes nothing.
- R5: Writing 20h at address 0 clears the in-service bit of the lowest-numbered line in service. Lower-priority requests that were blocked by that bit become eligible.
- R6: In edge mode (mode bit 0, the reset value) only a high-to-low transition creates a request. A line that stays low, or that rises, creates no further request.
- R7: In level mode (mode bit 1) the request equals the line level registered each cycle. Dropping the line withdraws an unacknowledged request. A line that is still high after end of interrupt requests again.
- R8: A command byte at address 0 whose bits [2:0] are 001 loads the vector base from bits [7:3]. The base resets to 08h.
- R9: A command whose bits [2:0] are 010 directs address-1 accesses to the trigger-mode register, and 011 directs them back to the mask (the reset choice). A read at address 1 returns the selected register.
- R10: A command whose bits [2:0] are 100 sets master mode to bit 3. In master mode, granting line 2 sets its in-service bit but produces no `vec_valid`. All other lines still return vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, line 0 highest priority |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command, 1 = mask or trigger-mode register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high at address 1 |
| inta | input | 1 | Interrupt acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector on `vec_out` is valid this cycle |
| vec_out | output | 8 | Interrupt vector |

## Verification
A line transition or a register write takes effect at the next clock edge, so `int_out` reflects it one cycle later. After an acknowledge, the vector and `vec_valid` appear in the cycle right after the `inta` edge, and an end-of-interrupt write changes `int_out` in the cycle after the write. `rdata` is combinational and is read before the next edge. The bench keeps a behavioural model that updates on the same edges as the design and compares `int_out`, `vec_valid` and the vector at every falling edge. Directed checks are also placed exactly one cycle after each stimulus.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NL   = 8;
    localparam int IDXW = $clog2(NL);
    localparam int BASEW = 8 - IDXW;

    localparam logic [7:0] CMD_EOI = 8'h20;
    localparam logic [2:0] OP_BASE     = 3'b001;
    localparam logic [2:0] OP_SEL_MODE = 3'b010;
    localparam logic [2:0] OP_SEL_MASK = 3'b011;
    localparam logic [2:0] OP_CASCADE  = 3'b100;

    typedef struct packed {
        logic [NL-1:0]    req;
        logic [NL-1:0]    prev;
        logic [NL-1:0]    mask;
        logic [NL-1:0]    mode;
        logic [NL-1:0]    isr;
        logic [BASEW-1:0] base;
        logic             master;
        logic             sel_mode;
        logic             vvalid;
        logic [7:0]       vec;
    } pic_state_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_req_next.sv
module pic_req_next #(
    parameter int N = 8
) (
    input  logic [N-1:0] line,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req_d
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic fall;
        assign fall     = prev[g] & ~line[g];
        // level lines follow the pin; edge lines hold until granted, a new fall wins
        assign req_d[g] = mode[g] ? line[g] : ((req[g] & ~clr[g]) | fall);
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import pic_pkg::*;
#(
    parameter int         CASC_LINE  = 2,
    parameter logic [7:0] RESET_BASE = 8'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] irq_in,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       inta,
    output logic       int_out,
    output logic       vec_valid,
    output logic [7:0] vec_out
);
    localparam pic_state_t RST_STATE = '{
        req: '0, prev: '0, mask: '1, mode: '0, isr: '0,
        base: RESET_BASE[7:IDXW], master: 1'b0, sel_mode: 1'b0,
        vvalid: 1'b0, vec: '0
    };

    pic_state_t s_q, s_d;

    logic [NL-1:0]   elig;
    logic            req_found, isr_found;
    logic [IDXW-1:0] req_idx, isr_idx;
    logic            grant, eoi, cmd_wr;
    logic [NL-1:0]   grant_oh, eoi_oh, req_nx;
    logic [NL-1:0]   isr_w, mask_w;
    logic            master_w, sel_mode_w;

    assign elig = s_q.req & ~s_q.mask;

    pic_prio #(.N(NL), .IW(IDXW)) u_pick_req (
        .bits(elig), .found(req_found), .idx(req_idx)
    );
    pic_prio #(.N(NL), .IW(IDXW)) u_pick_isr (
        .bits(s_q.isr), .found(isr_found), .idx(isr_idx)
    );

    assign int_out  = req_found && (!isr_found || (req_idx < isr_idx));
    assign grant    = inta && int_out;
    assign grant_oh = grant ? (NL'(1) << req_idx) : '0;
    assign eoi      = wr_en && !addr && (wdata == CMD_EOI);
    assign cmd_wr   = wr_en && !addr && (wdata != CMD_EOI);
    assign eoi_oh   = (eoi && isr_found) ? (NL'(1) << isr_idx) : '0;

    pic_req_next #(.N(NL)) u_req (
        .line(irq_in), .prev(s_q.prev), .mode(s_q.mode), .req(s_q.req),
        .clr(grant_oh), .req_d(req_nx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.prev   = irq_in;
        s_d.req    = req_nx;
        s_d.isr    = (s_q.isr & ~eoi_oh) | grant_oh;
        s_d.vvalid = grant && !(s_q.master && (req_idx == IDXW'(CASC_LINE)));
        if (grant) begin
            s_d.vec = {s_q.base, req_idx};
        end
        if (wr_en && addr) begin
            if (s_q.sel_mode) s_d.mode = wdata;
            else              s_d.mask = wdata;
        end
        if (cmd_wr) begin
            case (wdata[2:0])
                OP_BASE:     s_d.base     = wdata[7:IDXW];
                OP_SEL_MODE: s_d.sel_mode = 1'b1;
                OP_SEL_MASK: s_d.sel_mode = 1'b0;
                OP_CASCADE:  s_d.master   = wdata[3];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    assign rdata     = (rd_en && addr) ? (s_q.sel_mode ? s_q.mode : s_q.mask) : '0;
    assign vec_valid = s_q.vvalid;
    assign vec_out   = s_q.vec;

    assign isr_w      = s_q.isr;
    assign mask_w     = s_q.mask;
    assign master_w   = s_q.master;
    assign sel_mode_w = s_q.sel_mode;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int CASC_LINE = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       inta,
    input logic       int_out,
    input logic       vec_valid,
    input logic [7:0] vec_out,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] isr,
    input logic [7:0] mask,
    input logic       master,
    input logic       sel_mode
);
    p_vec_follows_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($past(inta) && $past(int_out)));

    p_grant_marks_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out) |=> (isr != 8'h00));

    p_eoi_retires_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata == 8'h20 && isr != 8'h00 && !(inta && int_out))
        |=> ($countones(isr) == $countones($past(isr)) - 1));

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && !sel_mode) |=> (mask == $past(wdata)));

    p_top_service_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        isr[0] |-> !int_out);

    p_master_defers_cascade_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && master) |-> (vec_out[2:0] != 3'(CASC_LINE)));
endmodule

bind prio_intc prio_intc_chk #(.CASC_LINE(CASC_LINE)) u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .int_out(int_out),
    .vec_valid(vec_valid), .vec_out(vec_out), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .isr(isr_w), .mask(mask_w), .master(master_w),
    .sel_mode(sel_mode_w)
);

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
module prio_intc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = 8'hFF;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, vec_out;
    logic       int_out, vec_valid;

    int  nchk = 0, nerr = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .inta(inta),
        .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // behavioural reference
    logic [7:0] m_req, m_prev, m_mask, m_mode, m_isr, m_base, m_vec;
    bit         m_master, m_sel, m_vv;

    function automatic int first_set(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit m_int();
        int h = first_set(m_req & ~m_mask);
        int s = first_set(m_isr);
        return (h < 8) && (h < s);
    endfunction

    always @(posedge clk) begin : model
        logic [7:0] n_req, n_isr;
        int h, s;
        bit g;
        if (!rst_n) begin
            m_req = 0; m_prev = 0; m_mask = 8'hFF; m_mode = 0; m_isr = 0;
            m_base = 8'h08; m_vec = 0; m_master = 0; m_sel = 0; m_vv = 0;
        end else begin
            h = first_set(m_req & ~m_mask);
            g = inta && m_int();
            n_isr = m_isr;
            if (wr_en && !addr && wdata == 8'h20) begin
                s = first_set(m_isr);
                if (s < 8) n_isr[s] = 1'b0;
            end
            if (g) n_isr[h] = 1'b1;
            for (int i = 0; i < 8; i++) begin
                if (m_mode[i]) n_req[i] = irq[i];
                else begin
                    n_req[i] = m_req[i];
                    if (g && h == i) n_req[i] = 1'b0;
                    if (m_prev[i] && !irq[i]) n_req[i] = 1'b1;
                end
            end
            m_vv = g && !(m_master && h == 2);
            if (g) m_vec = m_base + 8'(h);
            if (wr_en && addr) begin
                if (m_sel) m_mode = wdata; else m_mask = wdata;
            end
            if (wr_en && !addr && wdata != 8'h20) begin
                case (wdata[2:0])
                    3'b001: m_base = {wdata[7:3], 3'b000};
                    3'b010: m_sel = 1;
                    3'b011: m_sel = 0;
                    3'b100: m_master = wdata[3];
                    default: ;
                endcase
            end
            m_req = n_req; m_prev = irq; m_isr = n_isr;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 int_out vs model", 8'(int_out), 8'(m_int()));
            chk("R4 vec_valid vs model", 8'(vec_valid), 8'(m_vv));
            if (m_vv) chk("R1 vector vs model", vec_out, m_vec);
        end
    end

    task automatic wr(logic a, logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask
    task automatic ack();
        inta = 1;
        @(negedge clk);
        inta = 0;
    endtask
    task automatic set_line(int i, logic v);
        irq[i] = v;
        @(negedge clk);
    endtask
    task automatic rd(logic [7:0] exp, string tag);
        rd_en = 1; addr = 1;
        #1 chk(tag, rdata, exp);
        rd_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset int_out", 8'(int_out), 8'h00);
        rd(8'hFF, "R2 reset mask");

        set_line(5, 0);
        chk("R2 masked line silent", 8'(int_out), 8'h00);
        wr(1, 8'h00);
        chk("R2 latched request after unmask", 8'(int_out), 8'h01);
        ack();
        chk("R4 vec_valid after ack", 8'(vec_valid), 8'h01);
        chk("R1 vector line 5", vec_out, 8'h0D);
        @(negedge clk);
        chk("R4 vec_valid one cycle", 8'(vec_valid), 8'h00);

        set_line(6, 0);
        chk("R3 lower line blocked", 8'(int_out), 8'h00);
        set_line(3, 0);
        chk("R3 higher line preempts", 8'(int_out), 8'h01);
        ack();
        chk("R1 vector line 3", vec_out, 8'h0B);
        wr(0, 8'h20);
        chk("R5 line 5 still blocks 6", 8'(int_out), 8'h00);
        wr(0, 8'h20);
        chk("R5 second eoi releases 6", 8'(int_out), 8'h01);
        ack();
        chk("R1 vector line 6", vec_out, 8'h0E);
        wr(0, 8'h20);
        chk("R6 held-low lines no new request", 8'(int_out), 8'h00);
        set_line(3, 1); set_line(5, 1); set_line(6, 1);
        chk("R6 rising edges no request", 8'(int_out), 8'h00);

        irq[4] = 0; irq[2] = 0;
        @(negedge clk);
        ack();
        chk("R1 simultaneous picks line 2", vec_out, 8'h0A);
        wr(0, 8'h20);
        ack();
        chk("R1 then line 4", vec_out, 8'h0C);
        wr(0, 8'h20);
        set_line(2, 1); set_line(4, 1);

        wr(0, 8'h71);
        set_line(3, 0);
        ack();
        chk("R8 new base vector", vec_out, 8'h73);
        wr(0, 8'h20);
        set_line(3, 1);

        set_line(7, 0);
        wr(0, 8'h02);
        wr(1, 8'h80);
        rd(8'h80, "R9 mode readback");
        wr(0, 8'h03);
        rd(8'h00, "R9 mask readback");
        set_line(7, 1);
        chk("R7 level high requests", 8'(int_out), 8'h01);
        set_line(7, 0);
        chk("R7 level drop withdraws", 8'(int_out), 8'h00);
        set_line(7, 1);
        ack();
        chk("R7 level vector", vec_out, 8'h77);
        wr(0, 8'h20);
        chk("R7 still high re-requests", 8'(int_out), 8'h01);
        set_line(7, 0);
        wr(0, 8'h02);
        wr(1, 8'h00);
        wr(0, 8'h03);
        set_line(7, 1);
        chk("R6 rise in edge mode ignored", 8'(int_out), 8'h00);

        ack();
        chk("R4 ack without request no vector", 8'(vec_valid), 8'h00);

        wr(0, 8'h0C);
        set_line(2, 0);
        ack();
        chk("R10 master defers line 2 vector", 8'(vec_valid), 8'h00);
        set_line(4, 0);
        chk("R10 line 2 in service blocks 4", 8'(int_out), 8'h00);
        wr(0, 8'h20);
        chk("R10 eoi releases 4", 8'(int_out), 8'h01);
        ack();
        chk("R10 other lines give vectors", vec_out, 8'h74);
        wr(0, 8'h20);
        set_line(2, 1); set_line(4, 1);
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule